// File: doc/BRIEF.md
# Clock Monitor and Machine-Cycle Divider

This unit sits beside a small processor core and takes care of two clock-related jobs. First, it watches the main crystal clock from a second, free-running reference clock. If the main clock stops toggling for too long while monitoring is switched on, the unit raises a sticky failure flag. It also drives a reset output toward the rest of the chip, and that reset keeps working even though the main clock is dead. Halting the main clock for a stop mode looks the same as a failure, so software has to switch monitoring off before it halts the clock on purpose.

Second, it produces the one-cycle machine-cycle enable strobe that paces the core. A machine cycle is 4 main clocks at full speed. In the low-power mode it is 1024 main clocks. Software selects the mode through the control register. A mode change always waits for the current machine cycle to finish.

A single 8-bit control register in the main clock domain holds the monitor enable, the failure flag and the low-power mode request. The flag crosses to the main domain through synchronisers for read-back. Writing 0 to the flag bit clears it, and that request travels into the reference domain as a toggle.

Top module: `osc_clk_ctrl`

## Requirements
- R1: After power-up reset (`por_n` low), register read-back `reg_rdata` is 8'h00, `pmm_active` is 0 and `fail_rst_n` is 1.
- R2: With bit 2 of the control register at 0, `mc_stb` pulses high for one main clock once every 4 main clocks.
- R3: Writing bit 2 to 1 selects 1024 main clocks per machine cycle, and writing it to 0 selects 4 again. The change takes effect only at a strobe, so the machine cycle in progress keeps its old length. `pmm_active` shows the length in force (1 means 1024).
- R4: The mode only changes through a register write. A detected clock failure and its forced reset leave bit 2 and `pmm_active` unchanged.
- R5: While bit 4 (monitor enable) is 0, a main-clock halt of any length sets no flag and leaves `fail_rst_n` at 1.
- R6: While bit 4 is 1, a main-clock halt longer than `FAIL_THRESH` (default 64) reference cycles sets the flag (bit 5) and drives `fail_rst_n` low. A halt used for stop mode counts as a failure too.
- R7: Once the main clock toggles again, `fail_rst_n` stays low until it has been seen alive for `REC_CYCLES` (default 8) reference cycles and then returns to 1. The flag stays at 1. Clearing bit 4 also releases the reset.
- R8: The flag is cleared only by power-up reset or by a register write with bit 5 at 0. A write with bit 5 at 1 leaves it set.
- R9: A main-clock pause shorter than `FAIL_THRESH` reference cycles, with monitoring on, sets no flag and does not pull `fail_rst_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Main crystal clock being monitored and divided |
| clk_ref | input | 1 | Independent free-running reference clock |
| por_n | input | 1 | Power-up reset, active low, sampled in both domains |
| reg_wr | input | 1 | Control register write strobe (main domain) |
| reg_wdata | input | 8 | Write data: bit 2 low-power mode, bit 4 monitor enable, bit 5 flag (write 0 clears) |
| reg_rdata | output | 8 | Read-back: bit 2 mode request, bit 4 enable, bit 5 synchronised flag, others 0 |
| mc_stb | output | 1 | One-cycle machine-cycle enable strobe |
| pmm_active | output | 1 | 1 while 1024-clock machine cycles are in force |
| fail_rst_n | output | 1 | Clock-failure reset toward the system, active low |

## Verification
The bench watches the strobe spacing across both mode switches. A design that switched at the moment of the write would produce one machine cycle of partial length, 2 or 3 clocks or a few hundred. The bench halts the main clock in three ways: with monitoring off, for a pause shorter than the threshold, and for a halt longer than it. A monitor that ignored its enable, or that fired too early, would pull the reset low where it must stay high. After the main clock restarts, the bench samples the reset early and again late, which catches a release that ignores the alive window. It then writes a 1 and afterwards a 0 to the flag bit, which exposes a flag that clears on recovery or on any write, and it confirms that the mode survived the failure.

// File: rtl/clkctl_pkg.sv
// Shared constants and types for the clock monitor / machine-cycle unit.
// Assumes an 8-bit control register; bit positions are fixed because
// software decodes them.
package clkctl_pkg;
    localparam int CTL_W      = 8;
    localparam int PMM_BIT    = 2;
    localparam int DET_EN_BIT = 4;
    localparam int FAIL_BIT   = 5;

    typedef enum logic {
        MC_FAST = 1'b0,
        MC_SLOW = 1'b1
    } mc_mode_e;
endpackage

// File: rtl/clkctl_sync.sv
// Multi-stage flop synchroniser, one independent chain per bit.
// Assumes each bit is a level or a slow toggle that needs no
// coherence with its neighbours. It has no reset, so it can also
// bring the power-up reset into a foreign domain.
module clkctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the asynchronous input through the synchroniser stages.
    always_ff @(posedge clk) begin
        stage_q[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/clkctl_regs.sv
// Main-domain control register: monitor enable, low-power mode request
// and the flag-clear request, sent as a toggle. The flag itself lives in
// the reference domain; fail_seen is its synchronised copy for read-back.
// Assumes a synchronous active-low reset from power-up only.
module clkctl_regs
    import clkctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             fail_seen,
    output logic             det_en,
    output logic             pmm_req,
    output logic             clr_tgl,
    output logic [CTL_W-1:0] rdata
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // Capture software writes; a 0 written to the flag bit flips the clear toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_en  <= 1'b0;
            pmm_req <= 1'b0;
            clr_tgl <= 1'b0;
        end else if (wr) begin
            det_en  <= wdata[DET_EN_BIT];
            pmm_req <= wdata[PMM_BIT];
            if (!wdata[FAIL_BIT]) begin
                clr_tgl <= ~clr_tgl;
            end
        end
    end

    // Assemble the read-back word; unused bits read as zero.
    always_comb begin
        rdata             = '0;
        rdata[PMM_BIT]    = pmm_req;
        rdata[DET_EN_BIT] = det_en;
        rdata[FAIL_BIT]   = fail_seen;
    end

    // R4: the mode request only moves on a register write.
    a_r4_mode_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pmm_req) |-> $past(wr));
endmodule

// File: rtl/clkctl_mcgen.sv
// Machine-cycle strobe generator. It counts main clocks up to FAST_LEN or
// SLOW_LEN and takes on the requested mode only at the end of a cycle.
// Assumes pmm_req is synchronous to clk and FAST_LEN >= 2.
module clkctl_mcgen
    import clkctl_pkg::*;
#(
    parameter int FAST_LEN = 4,
    parameter int SLOW_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pmm_req,
    output logic mc_stb,
    output logic pmm_active
);
    localparam int CW = $clog2(SLOW_LEN);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_LEN - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_LEN - 1);

    mc_mode_e      mode_q;
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end     = (cnt_q == ((mode_q == MC_SLOW) ? SLOW_LAST : FAST_LAST));
    assign pmm_active = (mode_q == MC_SLOW);

    // Advance the cycle counter; at the boundary load the requested mode and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= MC_FAST;
            mc_stb <= 1'b0;
        end else begin
            mc_stb <= at_end;
            if (at_end) begin
                cnt_q  <= '0;
                mode_q <= pmm_req ? MC_SLOW : MC_FAST;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Checker state: spacing between strobes and the mode announced at each one.
    logic [CW-1:0] chk_gap;
    logic          chk_armed;
    logic          chk_slow;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_gap   <= '0;
            chk_armed <= 1'b0;
            chk_slow  <= 1'b0;
        end else if (mc_stb) begin
            chk_gap   <= '0;
            chk_armed <= 1'b1;
            chk_slow  <= pmm_active;
        end else begin
            chk_gap <= chk_gap + 1'b1;
        end
    end

    // R2 / R3: every machine cycle has the full length of the mode announced at its start.
    a_r3_no_partial_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_stb && chk_armed) |-> (chk_gap == (chk_slow ? SLOW_LAST : FAST_LAST)));
    // R3: the mode in force changes only together with a strobe.
    a_r3_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pmm_active) |-> mc_stb);
    // R2: the strobe is a single-cycle pulse.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mc_stb |=> !mc_stb);
endmodule

// File: rtl/clkctl_oscmon.sv
// Reference-domain clock watchdog. It counts reference cycles since the last
// transition of the synchronised main-clock divider and declares a failure at
// THRESH. It holds the sticky flag and the forced reset, and releases the
// reset once the main clock has been alive for REC_CYC cycles or monitoring is
// switched off. Assumes all inputs are already synchronised and ALIVE_GAP < THRESH.
module clkctl_oscmon #(
    parameter int THRESH    = 64,
    parameter int REC_CYC   = 8,
    parameter int ALIVE_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic mon_s,
    input  logic clr_s,
    output logic flag,
    output logic fail_rst_n
);
    localparam int IW = $clog2(THRESH + 1);
    localparam int RW = $clog2(REC_CYC + 1);
    localparam logic [IW-1:0] IDLE_MAX  = IW'(THRESH);
    localparam logic [IW-1:0] ALIVE_LIM = IW'(ALIVE_GAP);
    localparam logic [RW-1:0] REC_LAST  = RW'(REC_CYC - 1);

    logic          mon_q, clr_q;
    logic [IW-1:0] idle_cnt;
    logic [RW-1:0] rec_cnt;
    logic          fail_active;
    logic          mon_edge, clr_evt, fail_evt, alive;

    assign mon_edge   = mon_s ^ mon_q;
    assign clr_evt    = clr_s ^ clr_q;
    assign fail_evt   = en_s && (idle_cnt == IDLE_MAX);
    assign alive      = (idle_cnt < ALIVE_LIM);
    assign fail_rst_n = ~fail_active;

    // Remember the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            mon_q <= mon_s;
            clr_q <= clr_s;
        end
    end

    // Count reference cycles since the last main-clock activity, saturating at THRESH.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s || mon_edge) begin
            idle_cnt <= '0;
        end else if (idle_cnt != IDLE_MAX) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Count consecutive alive cycles while the forced reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n || !fail_active || !alive) begin
            rec_cnt <= '0;
        end else if (rec_cnt != REC_LAST) begin
            rec_cnt <= rec_cnt + 1'b1;
        end
    end

    // Assert the forced reset on failure; drop it after recovery or on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_s) begin
            fail_active <= 1'b0;
        end else if (fail_evt) begin
            fail_active <= 1'b1;
        end else if (fail_active && alive && (rec_cnt == REC_LAST)) begin
            fail_active <= 1'b0;
        end
    end

    // Sticky failure flag: set by detection, cleared only by software or power-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (fail_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

    // R8: the flag falls only after a software clear request.
    a_r8_flag_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr_evt));
    // R6: a forced reset is always accompanied by the flag.
    a_r6_reset_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !fail_rst_n |-> flag);
    // R5: with monitoring off the forced reset is released.
    a_r5_off_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> fail_rst_n);
    // R7: release only with the monitor disabled or the main clock alive.
    a_r7_release_alive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_rst_n) |-> ($past(!en_s) || $past(alive)));
endmodule

// File: rtl/osc_clk_ctrl.sv
// Top level of the clock monitor and machine-cycle divider. The main domain
// holds the register and the strobe generator; the reference domain holds the
// watchdog. Crossings are single bits through flop synchronisers. Assumes the
// reference clock keeps running and por_n is held for a few cycles of both clocks.
module osc_clk_ctrl
    import clkctl_pkg::*;
#(
    parameter int FAIL_THRESH = 64,
    parameter int REC_CYCLES  = 8,
    parameter int ALIVE_GAP   = 4,
    parameter int MON_DIV_W   = 2,
    parameter int FAST_LEN    = 4,
    parameter int SLOW_LEN    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_main,
    input  logic             clk_ref,
    input  logic             por_n,
    input  logic             reg_wr,
    input  logic [CTL_W-1:0] reg_wdata,
    output logic [CTL_W-1:0] reg_rdata,
    output logic             mc_stb,
    output logic             pmm_active,
    output logic             fail_rst_n
);
    logic                 det_en, pmm_req, clr_tgl, fail_seen, ref_flag;
    logic [MON_DIV_W-1:0] mon_div;
    logic                 ref_rst_n;
    logic [2:0]           ref_in_s;

    // Free-running divider whose top bit is the main-clock heartbeat.
    always_ff @(posedge clk_main) begin
        if (!por_n) begin
            mon_div <= '0;
        end else begin
            mon_div <= mon_div + 1'b1;
        end
    end

    clkctl_regs u_regs (
        .clk       (clk_main),
        .rst_n     (por_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .fail_seen (fail_seen),
        .det_en    (det_en),
        .pmm_req   (pmm_req),
        .clr_tgl   (clr_tgl),
        .rdata     (reg_rdata)
    );

    clkctl_mcgen #(
        .FAST_LEN (FAST_LEN),
        .SLOW_LEN (SLOW_LEN)
    ) u_mcgen (
        .clk        (clk_main),
        .rst_n      (por_n),
        .pmm_req    (pmm_req),
        .mc_stb     (mc_stb),
        .pmm_active (pmm_active)
    );

    clkctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_por (
        .clk (clk_ref),
        .d   (por_n),
        .q   (ref_rst_n)
    );

    clkctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_ref (
        .clk (clk_ref),
        .d   ({det_en, mon_div[MON_DIV_W-1], clr_tgl}),
        .q   (ref_in_s)
    );

    clkctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_flag (
        .clk (clk_main),
        .d   (ref_flag),
        .q   (fail_seen)
    );

    clkctl_oscmon #(
        .THRESH    (FAIL_THRESH),
        .REC_CYC   (REC_CYCLES),
        .ALIVE_GAP (ALIVE_GAP)
    ) u_oscmon (
        .clk        (clk_ref),
        .rst_n      (ref_rst_n),
        .en_s       (ref_in_s[2]),
        .mon_s      (ref_in_s[1]),
        .clr_s      (ref_in_s[0]),
        .flag       (ref_flag),
        .fail_rst_n (fail_rst_n)
    );

    // R1: while power-up reset is applied the system reset output is released.
    a_r1_por_release: assert property (@(posedge clk_ref)
        !ref_rst_n |=> fail_rst_n);
endmodule

// File: tb/test_osc_clk_ctrl.sv
`timescale 1ns/1ps
module test_osc_clk_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int REF_PERIOD = 26;

    logic       clk_main = 1'b0;
    logic       clk_ref  = 1'b0;
    logic       main_run = 1'b1;
    logic       por_n    = 1'b0;
    logic       reg_wr   = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       mc_stb, pmm_active, fail_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    int since  = 0;
    int last_gap = 0;
    event stb_ev;

    osc_clk_ctrl i_osc_clk_ctrl (
        .clk_main   (clk_main),
        .clk_ref    (clk_ref),
        .por_n      (por_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mc_stb     (mc_stb),
        .pmm_active (pmm_active),
        .fail_rst_n (fail_rst_n)
    );

    always begin
        #(CLK_PERIOD/2);
        if (main_run) clk_main = ~clk_main;
    end
    always #(REF_PERIOD/2) clk_ref = ~clk_ref;

    // Measure the spacing between strobes in main clocks.
    always @(negedge clk_main) begin
        if (mc_stb) begin
            last_gap = since + 1;
            since = 0;
            -> stb_ev;
        end else begin
            since++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk_main);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk_main);
        reg_wr = 1'b0;
    endtask

    task automatic ref_wait(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic settle_read;
        ref_wait(10);
        repeat (4) @(negedge clk_main);
    endtask

    task automatic t_reset;
        repeat (10) @(negedge clk_main);
        por_n = 1'b1;
        ref_wait(4);
        @(negedge clk_main);
        check(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        check(pmm_active == 1'b0, "R1 pmm_active", pmm_active, 0);
        check(fail_rst_n == 1'b1, "R1 fail_rst_n", fail_rst_n, 1);
    endtask

    task automatic t_fast_period;
        @(stb_ev);
        for (int i = 0; i < 3; i++) begin
            @(stb_ev);
            check(last_gap == 4, "R2 strobe gap", last_gap, 4);
        end
    endtask

    task automatic t_disabled_halt;
        write_reg(8'h00);
        ref_wait(6);
        main_run = 1'b0;
        ref_wait(100);
        check(fail_rst_n == 1'b1, "R5 no reset while disabled", fail_rst_n, 1);
        main_run = 1'b1;
        settle_read();
        check(reg_rdata[5] == 1'b0, "R5 no flag while disabled", reg_rdata[5], 0);
    endtask

    task automatic t_short_pause;
        write_reg(8'h10);
        ref_wait(6);
        main_run = 1'b0;
        ref_wait(20);
        check(fail_rst_n == 1'b1, "R9 short pause no reset", fail_rst_n, 1);
        main_run = 1'b1;
        settle_read();
        check(reg_rdata[5] == 1'b0, "R9 short pause no flag", reg_rdata[5], 0);
    endtask

    task automatic t_enter_slow;
        @(stb_ev);
        write_reg(8'h14);
        @(stb_ev);
        check(last_gap == 4, "R3 cycle in progress keeps 4", last_gap, 4);
        check(pmm_active == 1'b1, "R3 pmm_active set", pmm_active, 1);
        @(stb_ev);
        check(last_gap == 1024, "R3 slow cycle length", last_gap, 1024);
    endtask

    task automatic t_fail_and_recover;
        main_run = 1'b0;
        ref_wait(80);
        check(fail_rst_n == 1'b0, "R6 halt forces reset", fail_rst_n, 0);
        main_run = 1'b1;
        ref_wait(4);
        check(fail_rst_n == 1'b0, "R7 reset held during recovery", fail_rst_n, 0);
        ref_wait(20);
        check(fail_rst_n == 1'b1, "R7 reset released", fail_rst_n, 1);
        repeat (4) @(negedge clk_main);
        check(reg_rdata[5] == 1'b1, "R6 flag set and sticky", reg_rdata[5], 1);
        check(reg_rdata[2] == 1'b1, "R4 mode bit kept", reg_rdata[2], 1);
        check(pmm_active == 1'b1, "R4 pmm_active kept", pmm_active, 1);
    endtask

    task automatic t_flag_clear;
        write_reg(8'h34);
        settle_read();
        check(reg_rdata[5] == 1'b1, "R8 write 1 keeps flag", reg_rdata[5], 1);
        write_reg(8'h14);
        settle_read();
        check(reg_rdata[5] == 1'b0, "R8 write 0 clears flag", reg_rdata[5], 0);
    endtask

    task automatic t_leave_slow;
        @(stb_ev);
        write_reg(8'h10);
        @(stb_ev);
        check(last_gap == 1024, "R3 slow cycle completes", last_gap, 1024);
        check(pmm_active == 1'b0, "R3 pmm_active cleared", pmm_active, 0);
        @(stb_ev);
        check(last_gap == 4, "R3 back to 4", last_gap, 4);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fast_period();
        t_disabled_halt();
        t_short_pause();
        t_enter_slow();
        t_fail_and_recover();
        t_flag_clear();
        t_leave_slow();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule